// File: doc/BRIEF.md
# Message-Signalled Interrupt Capability Slice

This block holds the configuration-space words of a PCI Express message-signalled interrupt capability and turns interrupt requests into ready-to-send messages. A simple register port gives read and write access to three or four 32-bit words: a capability header with an enable bit, the low and high halves of the message address, and the message data. Where the words sit depends on the `is64_i` input. When 64-bit addressing is supported, the high address word is mapped and the data word moves up by four bytes.

On the request side an agent presents a vector number with a valid/ready handshake. If messaging is enabled and the vector lies within the allowed count, the block latches a 64-bit address and a 16-bit data value. It presents them on its message port until the consumer accepts them. The allowed count is a power of two, given as its log2 on `vec_log2_i`, and the vector number replaces that many low bits of the programmed data value. A vector outside the allowed range is dropped and a one-cycle error pulse is raised.

Top module: `msi_cap_slice`

## Requirements
- R1: A read of offset CAP_BASE (default 0x050) returns 0x05 in bits [7:0], the next-capability pointer in bits [15:8] (0x68 when NEXT_SEL=0, 0x78 otherwise), the enable in bit 16 and 0 in bits [31:17]; writes change only bit 16.
- R2: Header bit 16 is the read/write enable, reset to 0; while it is 0, `req_ready_o` stays low and no message is produced.
- R3: Offset CAP_BASE+4 holds the low address word: bits [31:2] are read/write and bits [1:0] always read 0, and `msg_addr_o[1:0]` is always 0.
- R4: With `is64_i`=1, offset CAP_BASE+8 is the read/write high address word, the data word sits at CAP_BASE+12, and the message address is {high word, low word}.
- R5: With `is64_i`=0, the data word sits at CAP_BASE+8, CAP_BASE+12 is unmapped, and `msg_addr_o[63:32]` is 0.
- R6: Data word bits [15:0] are read/write; bits [31:16] read 0 and ignore writes.
- R7: For an accepted request with effective log2 count k (`vec_log2_i`, with values above 5 treated as 5), `msg_data_o` equals the data word with its low k bits replaced by the vector number; with k=0 it is the data word unchanged.
- R8: A request whose vector is 2^k or above is consumed without a message, and `err_o` is high for exactly the cycle after acceptance.
- R9: Once `msg_valid_o` rises, it and `msg_addr_o`/`msg_data_o` stay constant until a cycle with `msg_ready_i` high, even if the registers are rewritten meanwhile.
- R10: Reads of unmapped offsets return 0, and writes to unmapped offsets or read-only bits change no readable value.
- R11: `cfg_rvalid_o` is high exactly in the cycle after a cycle with `cfg_rd_i` high, carrying the value before any write of that same cycle; `cfg_rdata_o` is 0 in other cycles.
- R12: Synchronous active-high reset clears the enable, all address and data bits, `msg_valid_o`, `err_o` and `cfg_rvalid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| is64_i | input | 1 | 64-bit message addressing supported |
| vec_log2_i | input | 3 | log2 of the number of allowed vectors |
| cfg_wr_i | input | 1 | Register write strobe |
| cfg_rd_i | input | 1 | Register read strobe |
| cfg_addr_i | input | 12 | Byte offset in configuration space |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Read data, registered |
| cfg_rvalid_o | output | 1 | Read data valid |
| req_valid_i | input | 1 | Interrupt request present |
| req_vec_i | input | 5 | Requested vector number |
| req_ready_o | output | 1 | Request accepted this cycle if valid |
| msg_valid_o | output | 1 | Message pending |
| msg_addr_o | output | 64 | Message address |
| msg_data_o | output | 16 | Message data |
| msg_ready_i | input | 1 | Consumer takes the message |
| err_o | output | 1 | Vector out of range pulse |

## Verification
The hardest situation to reach is a pending message that is held while the registers it was built from are rewritten. The stimulus lowers `msg_ready_i`, gets one request accepted, and then writes a new data word while the message waits. The bench then confirms that address and data keep their latched values until the consumer accepts. The remap between 32-bit and 64-bit layouts is reached by resetting the block with `is64_i` flipped and repeating accesses at the shared offset.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;
  localparam logic [7:0] MSI_CAP_ID  = 8'h05;
  localparam logic [7:0] NXT_PTR_LO  = 8'h68;
  localparam logic [7:0] NXT_PTR_HI  = 8'h78;
  localparam int         HDR_EN_BIT  = 16;
  localparam int         DATA_W      = 16;

  typedef struct packed {
    logic [63:0]       addr;
    logic [DATA_W-1:0] data;
  } msi_msg_t;
endpackage

// File: rtl/msi_cfg_regs.sv
module msi_cfg_regs
  import msi_cap_pkg::*;
#(
  parameter int              AW       = 12,
  parameter logic [AW-1:0]   CAP_BASE = 12'h050,
  parameter int              NEXT_SEL = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              is64_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              rvalid_o,
  output logic              en_o,
  output logic [31:0]       addr_lo_o,
  output logic [31:0]       addr_hi_o,
  output logic [DATA_W-1:0] data_o
);
  localparam logic [AW-1:0] OFF_HDR = CAP_BASE;
  localparam logic [AW-1:0] OFF_LO  = CAP_BASE + AW'(4);
  localparam logic [AW-1:0] OFF_W8  = CAP_BASE + AW'(8);
  localparam logic [AW-1:0] OFF_WC  = CAP_BASE + AW'(12);
  localparam logic [7:0]    NXT     = (NEXT_SEL != 0) ? NXT_PTR_HI : NXT_PTR_LO;

  logic              en_q;
  logic [31:2]       lo_q;
  logic [31:0]       hi_q;
  logic [DATA_W-1:0] dat_q;
  logic [31:0]       rdata_q;
  logic              rvalid_q;

  logic hit_hdr, hit_lo, hit_hi, hit_dat;
  logic [31:0] rd_mux;

  always_comb begin
    hit_hdr = (addr_i == OFF_HDR);
    hit_lo  = (addr_i == OFF_LO);
    hit_hi  = is64_i && (addr_i == OFF_W8);
    hit_dat = is64_i ? (addr_i == OFF_WC) : (addr_i == OFF_W8);
  end

  always_comb begin
    rd_mux = '0;
    if (hit_hdr)      rd_mux = {15'd0, en_q, NXT, MSI_CAP_ID};
    else if (hit_lo)  rd_mux = {lo_q, 2'b00};
    else if (hit_hi)  rd_mux = hi_q;
    else if (hit_dat) rd_mux = {{(32-DATA_W){1'b0}}, dat_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      lo_q     <= '0;
      hi_q     <= '0;
      dat_q    <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_i;
      rdata_q  <= rd_i ? rd_mux : 32'd0;
      if (wr_i) begin
        if (hit_hdr) en_q  <= wdata_i[HDR_EN_BIT];
        if (hit_lo)  lo_q  <= wdata_i[31:2];
        if (hit_hi)  hi_q  <= wdata_i;
        if (hit_dat) dat_q <= wdata_i[DATA_W-1:0];
      end
    end
  end

  assign rdata_o   = rdata_q;
  assign rvalid_o  = rvalid_q;
  assign en_o      = en_q;
  assign addr_lo_o = {lo_q, 2'b00};
  assign addr_hi_o = is64_i ? hi_q : 32'd0;
  assign data_o    = dat_q;

  // R11: a read strobe yields valid read data on the next cycle
  assert_rvalid_follows_R11: assert property (@(posedge clk) disable iff (rst)
    rd_i |=> rvalid_o);
  // R11: no read data outside valid cycles
  assert_rdata_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !rvalid_o |-> (rdata_o == 32'd0));
endmodule

// File: rtl/msi_msg_build.sv
module msi_msg_build
  import msi_cap_pkg::*;
#(
  parameter int VEC_W = 5,
  parameter int LOG_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic [31:0]       addr_lo_i,
  input  logic [31:0]       addr_hi_i,
  input  logic [DATA_W-1:0] data_base_i,
  input  logic [LOG_W-1:0]  log2_i,
  input  logic              req_valid_i,
  input  logic [VEC_W-1:0]  req_vec_i,
  output logic              req_ready_o,
  output logic              msg_valid_o,
  output logic [63:0]       msg_addr_o,
  output logic [DATA_W-1:0] msg_data_o,
  input  logic              msg_ready_i,
  output logic              err_o
);
  localparam int PAD_W = DATA_W - VEC_W;

  logic [LOG_W-1:0]  eff_log2;
  logic [VEC_W-1:0]  vmask;
  logic [DATA_W-1:0] mask16;
  logic [DATA_W-1:0] composed;
  logic              out_of_range;
  logic              accept;

  logic     mv_q;
  logic     err_q;
  msi_msg_t msg_q;

  assign eff_log2 = (log2_i > LOG_W'(VEC_W)) ? LOG_W'(VEC_W) : log2_i;

  for (genvar g = 0; g < VEC_W; g++) begin : g_mask
    assign vmask[g] = (eff_log2 > LOG_W'(g));
  end

  assign mask16       = {{PAD_W{1'b0}}, vmask};
  assign composed     = (data_base_i & ~mask16) | ({{PAD_W{1'b0}}, req_vec_i} & mask16);
  assign out_of_range = |(req_vec_i & ~vmask);
  assign req_ready_o  = en_i && !mv_q;
  assign accept       = req_valid_i && req_ready_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      mv_q  <= 1'b0;
      err_q <= 1'b0;
      msg_q <= '0;
    end else begin
      err_q <= accept && out_of_range;
      if (accept && !out_of_range) begin
        mv_q       <= 1'b1;
        msg_q.addr <= {addr_hi_i, addr_lo_i};
        msg_q.data <= composed;
      end else if (mv_q && msg_ready_i) begin
        mv_q <= 1'b0;
      end
    end
  end

  assign msg_valid_o = mv_q;
  assign msg_addr_o  = msg_q.addr;
  assign msg_data_o  = msg_q.data;
  assign err_o       = err_q;

  // R9: pending message held stable until taken
  assert_msg_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (msg_valid_o && !msg_ready_i) |=> (msg_valid_o && $stable(msg_addr_o) && $stable(msg_data_o)));
  // R2: a message only starts when enabled in the accepting cycle
  assert_no_msg_disabled_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(msg_valid_o) |-> $past(en_i));
  // R8: a refused vector never starts a message
  assert_err_no_msg_R8: assert property (@(posedge clk) disable iff (rst)
    err_o |-> !$rose(msg_valid_o));
  // R8: error is a single-cycle pulse
  assert_err_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    err_o |=> !err_o || $past(req_valid_i));
endmodule

// File: rtl/msi_cap_slice.sv
module msi_cap_slice
  import msi_cap_pkg::*;
#(
  parameter int            AW       = 12,
  parameter logic [AW-1:0] CAP_BASE = 12'h050,
  parameter int            NEXT_SEL = 0,
  parameter int            VEC_W    = 5,
  localparam int           LOG_W    = $clog2(VEC_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              is64_i,
  input  logic [LOG_W-1:0]  vec_log2_i,
  input  logic              cfg_wr_i,
  input  logic              cfg_rd_i,
  input  logic [AW-1:0]     cfg_addr_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic [31:0]       cfg_rdata_o,
  output logic              cfg_rvalid_o,
  input  logic              req_valid_i,
  input  logic [VEC_W-1:0]  req_vec_i,
  output logic              req_ready_o,
  output logic              msg_valid_o,
  output logic [63:0]       msg_addr_o,
  output logic [DATA_W-1:0] msg_data_o,
  input  logic              msg_ready_i,
  output logic              err_o
);
  logic              en;
  logic [31:0]       addr_lo;
  logic [31:0]       addr_hi;
  logic [DATA_W-1:0] data_base;

  msi_cfg_regs #(
    .AW(AW), .CAP_BASE(CAP_BASE), .NEXT_SEL(NEXT_SEL)
  ) u_regs (
    .clk(clk), .rst(rst), .is64_i(is64_i),
    .wr_i(cfg_wr_i), .rd_i(cfg_rd_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .rdata_o(cfg_rdata_o), .rvalid_o(cfg_rvalid_o),
    .en_o(en), .addr_lo_o(addr_lo), .addr_hi_o(addr_hi), .data_o(data_base)
  );

  msi_msg_build #(
    .VEC_W(VEC_W), .LOG_W(LOG_W)
  ) u_build (
    .clk(clk), .rst(rst), .en_i(en),
    .addr_lo_i(addr_lo), .addr_hi_i(addr_hi), .data_base_i(data_base),
    .log2_i(vec_log2_i), .req_valid_i(req_valid_i), .req_vec_i(req_vec_i),
    .req_ready_o(req_ready_o), .msg_valid_o(msg_valid_o),
    .msg_addr_o(msg_addr_o), .msg_data_o(msg_data_o),
    .msg_ready_i(msg_ready_i), .err_o(err_o)
  );

  // R3: message address stays Dword aligned
  assert_addr_align_R3: assert property (@(posedge clk) disable iff (rst)
    msg_valid_o |-> (msg_addr_o[1:0] == 2'b00));
  // R5: upper address is zero without 64-bit support
  assert_upper_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (msg_valid_o && !is64_i) |-> (msg_addr_o[63:32] == 32'd0));
endmodule

// File: tb/tb_msi_cap_slice.sv
module tb_msi_cap_slice;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        is64_i;
  logic [2:0]  vec_log2_i;
  logic        cfg_wr_i, cfg_rd_i;
  logic [11:0] cfg_addr_i;
  logic [31:0] cfg_wdata_i;
  logic [31:0] cfg_rdata_o;
  logic        cfg_rvalid_o;
  logic        req_valid_i;
  logic [4:0]  req_vec_i;
  logic        req_ready_o, msg_valid_o, msg_ready_i, err_o;
  logic [63:0] msg_addr_o;
  logic [15:0] msg_data_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit started = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  msi_cap_slice dut (
    .clk(clk), .rst(rst), .is64_i(is64_i), .vec_log2_i(vec_log2_i),
    .cfg_wr_i(cfg_wr_i), .cfg_rd_i(cfg_rd_i), .cfg_addr_i(cfg_addr_i),
    .cfg_wdata_i(cfg_wdata_i), .cfg_rdata_o(cfg_rdata_o), .cfg_rvalid_o(cfg_rvalid_o),
    .req_valid_i(req_valid_i), .req_vec_i(req_vec_i), .req_ready_o(req_ready_o),
    .msg_valid_o(msg_valid_o), .msg_addr_o(msg_addr_o), .msg_data_o(msg_data_o),
    .msg_ready_i(msg_ready_i), .err_o(err_o)
  );

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: got %h expected %h", tag, $time, got, exp);
    end
  endtask

  // behavioural reference model
  bit          m_en, m_mv, m_err, m_rvalid;
  logic [31:0] m_lo, m_hi, m_rdata;
  logic [15:0] m_dat, m_mdata;
  logic [63:0] m_maddr;

  function automatic logic [31:0] model_read(input logic [11:0] a);
    if (a == 12'h050) return 32'h0000_6805 | (m_en ? 32'h0001_0000 : 32'h0);
    if (a == 12'h054) return m_lo;
    if (a == 12'h058) return is64_i ? m_hi : {16'h0, m_dat};
    if (a == 12'h05C && is64_i) return {16'h0, m_dat};
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    int k, n;
    bit nx_en, nx_mv, nx_err;
    logic [31:0] nx_lo, nx_hi;
    logic [15:0] nx_dat;
    started = 1;
    if (rst) begin
      m_en = 0; m_mv = 0; m_err = 0; m_rvalid = 0;
      m_lo = 0; m_hi = 0; m_dat = 0; m_rdata = 0; m_maddr = 0; m_mdata = 0;
    end else begin
      nx_en = m_en; nx_mv = m_mv; nx_err = 0;
      nx_lo = m_lo; nx_hi = m_hi; nx_dat = m_dat;
      m_rdata  = cfg_rd_i ? model_read(cfg_addr_i) : 32'h0;
      m_rvalid = cfg_rd_i;
      if (req_valid_i && m_en && !m_mv) begin
        k = (vec_log2_i > 5) ? 5 : int'(vec_log2_i);
        n = 1 << k;
        if (int'(req_vec_i) >= n) nx_err = 1;
        else begin
          nx_mv   = 1;
          m_maddr = is64_i ? {m_hi, m_lo} : {32'h0, m_lo};
          m_mdata = 16'((int'(m_dat) / n) * n + int'(req_vec_i));
        end
      end else if (m_mv && msg_ready_i) nx_mv = 0;
      if (cfg_wr_i) begin
        if (cfg_addr_i == 12'h050) nx_en = cfg_wdata_i[16];
        if (cfg_addr_i == 12'h054) nx_lo = cfg_wdata_i & 32'hFFFF_FFFC;
        if (cfg_addr_i == 12'h058 && is64_i) nx_hi = cfg_wdata_i;
        if ((cfg_addr_i == 12'h058 && !is64_i) || (cfg_addr_i == 12'h05C && is64_i))
          nx_dat = cfg_wdata_i[15:0];
      end
      m_en = nx_en; m_mv = nx_mv; m_err = nx_err;
      m_lo = nx_lo; m_hi = nx_hi; m_dat = nx_dat;
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      check("R11 rvalid", {63'h0, cfg_rvalid_o}, {63'h0, m_rvalid});
      check("R11 rdata", {32'h0, cfg_rdata_o}, {32'h0, m_rdata});
      check("R2 req_ready", {63'h0, req_ready_o}, {63'h0, (m_en && !m_mv)});
      check("R9 msg_valid", {63'h0, msg_valid_o}, {63'h0, m_mv});
      check("R8 err", {63'h0, err_o}, {63'h0, m_err});
      if (m_mv) begin
        check("R4 msg_addr", msg_addr_o, m_maddr);
        check("R7 msg_data", {48'h0, msg_data_o}, {48'h0, m_mdata});
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_i = 1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk);
    cfg_wr_i = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    cfg_rd_i = 1; cfg_addr_i = a;
    @(negedge clk);
    cfg_rd_i = 0;
    check(tag, {32'h0, cfg_rdata_o}, {32'h0, exp});
  endtask

  task automatic req(input string tag, input logic [2:0] l2, input logic [4:0] v,
                     input bit exp_ok, input logic [63:0] exp_a, input logic [15:0] exp_d);
    @(negedge clk);
    vec_log2_i = l2; req_valid_i = 1; req_vec_i = v;
    @(negedge clk);
    req_valid_i = 0;
    check(tag, {63'h0, msg_valid_o}, {63'h0, exp_ok});
    check(tag, {63'h0, err_o}, {63'h0, !exp_ok});
    if (exp_ok) begin
      check(tag, msg_addr_o, exp_a);
      check(tag, {48'h0, msg_data_o}, {48'h0, exp_d});
    end
  endtask

  initial begin
    rst = 1; is64_i = 1; vec_log2_i = 0; cfg_wr_i = 0; cfg_rd_i = 0;
    cfg_addr_i = 0; cfg_wdata_i = 0; req_valid_i = 0; req_vec_i = 0; msg_ready_i = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    // R12 / R1: reset state of header and address
    rd_chk("R12 header after reset", 12'h050, 32'h0000_6805);
    rd_chk("R12 lo after reset", 12'h054, 32'h0);
    // R3: low two bits forced to zero
    wr(12'h054, 32'hDEAD_BEEF);
    rd_chk("R3 lo align", 12'h054, 32'hDEAD_BEEC);
    // R4: high word at +8 in 64-bit mode
    wr(12'h058, 32'h1234_5678);
    rd_chk("R4 hi word", 12'h058, 32'h1234_5678);
    // R6: data at +12, upper half reserved
    wr(12'h05C, 32'hFFFF_A5A5);
    rd_chk("R6 data word", 12'h05C, 32'h0000_A5A5);
    // R10: unmapped offset
    wr(12'h060, 32'hFFFF_FFFF);
    rd_chk("R10 unmapped", 12'h060, 32'h0);
    // R2: disabled request is not taken
    @(negedge clk);
    req_valid_i = 1; req_vec_i = 0;
    repeat (3) begin
      @(negedge clk);
      check("R2 ready low while disabled", {63'h0, req_ready_o}, 64'h0);
      check("R2 no msg while disabled", {63'h0, msg_valid_o}, 64'h0);
    end
    req_valid_i = 0;
    // R1: only bit 16 writable
    wr(12'h050, 32'hFFFF_FFFF);
    rd_chk("R1 header enabled", 12'h050, 32'h0001_6805);
    // R9: message held while consumer stalls
    msg_ready_i = 0;
    req("R7 vec3 of 4", 3'd2, 5'd3, 1, 64'h1234_5678_DEAD_BEEC, 16'hA5A7);
    wr(12'h05C, 32'h0);
    wr(12'h054, 32'h0);
    check("R9 held valid", {63'h0, msg_valid_o}, 64'h1);
    check("R9 held data", {48'h0, msg_data_o}, 64'hA5A7);
    check("R9 held addr", msg_addr_o, 64'h1234_5678_DEAD_BEEC);
    msg_ready_i = 1;
    @(negedge clk);
    check("R9 released", {63'h0, msg_valid_o}, 64'h0);
    wr(12'h05C, 32'h0000_1235);
    wr(12'h054, 32'h0000_0040);
    // R8: out of range
    req("R8 vec4 of 4", 3'd2, 5'd4, 0, 64'h0, 16'h0);
    @(negedge clk);
    check("R8 err pulse ends", {63'h0, err_o}, 64'h0);
    req("R7 single vector", 3'd0, 5'd0, 1, 64'h1234_5678_0000_0040, 16'h1235);
    req("R7 log2 clamp", 3'd7, 5'd31, 1, 64'h1234_5678_0000_0040, 16'h123F);
    req("R8 vec16 of 16", 3'd4, 5'd16, 0, 64'h0, 16'h0);
    // R2: disabling stops acceptance
    wr(12'h050, 32'h0);
    @(negedge clk);
    check("R2 ready low after disable", {63'h0, req_ready_o}, 64'h0);
    // R12: reset clears enable; switch to 32-bit layout
    wr(12'h050, 32'h0001_0000);
    @(negedge clk);
    rst = 1; is64_i = 0;
    repeat (2) @(negedge clk);
    rst = 0;
    rd_chk("R12 enable cleared", 12'h050, 32'h0000_6805);
    rd_chk("R12 data cleared", 12'h058, 32'h0);
    // R5: data at +8, +12 unmapped
    wr(12'h058, 32'hFFFF_BEEE);
    rd_chk("R5 data at +8", 12'h058, 32'h0000_BEEE);
    rd_chk("R5 +12 unmapped", 12'h05C, 32'h0);
    wr(12'h05C, 32'hFFFF_FFFF);
    rd_chk("R10 write to unmapped ignored", 12'h058, 32'h0000_BEEE);
    wr(12'h054, 32'h0000_0103);
    rd_chk("R3 lo align 32", 12'h054, 32'h0000_0100);
    wr(12'h050, 32'h0001_0000);
    req("R5 32-bit message", 3'd1, 5'd1, 1, 64'h0000_0000_0000_0100, 16'hBEEF);
    repeat (3) @(negedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL R12 watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule